// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block takes up to eight asynchronous interrupt pins from outside the chip and turns them into interrupt requests for an interrupt controller further downstream. Each pin is first passed through a two-flop synchroniser. It is then checked against its programmed sense type: falling edge, rising edge, low level, high level or both edges. A detected event is held in a pending bit. The pending bit is gated by a mask bit and by a 4-bit priority field, and the result drives that pin's request line. A combined request line is also driven, which is the OR of all the pin lines.

Software reaches the block over a simple word-addressed register bus. There are six registers:
- a sense-type register
- a priority register
- a pending-source register, whose bits are cleared by writing zeros
- a write-only set-mask strobe
- a write-only clear-mask strobe
- a mode register

The mode register decides how pins 0 to 3 are used. Either they act as four separate interrupt pins, or they are read together as a 4-bit encoded level. In the encoded case the level appears on a dedicated output and those four pins raise no individual requests. Priority arbitration and vectoring happen outside this block.

Top module: `extirq_pinctl`

## Requirements
- R1: On reset, every pin is masked, the sense, priority, pending and mode registers read 0, and every request output is low. A pin that becomes pending after reset stays silent until it is unmasked.
- R2: The sense register (word 0) gives each pin a SENSE_W-bit field at bit offset 32-(n+1)*SENSE_W. The priority register (word 1) gives each pin a 4-bit field at offset 32-(n+1)*4. Pin 0 therefore holds the top field in both registers, and both registers read back what was written.
- R3: Sense code 1 latches a pending bit on a rising edge and code 0 latches one on a falling edge. The pending bit stays set until it is cleared, and it becomes visible 3 clock edges after the pin changes. In the pending-source register (word 2), pin n's bit sits at bit SRC_W-1-n.
- R4: Sense code 4 latches a pending bit on either edge.
- R5: Under sense code 2 (active low) or code 3 (active high), the pending bit follows the synchronised pin. A write that clears the bit has no effect while the level is still active.
- R6: A write to the pending-source register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R7: A write to word 3 masks every pin whose bit is 1, and a write to word 4 unmasks every pin whose bit is 1. Both words use the same bit positions as the pending register, and 0 bits change nothing.
- R8: A pin whose priority field is 0 raises no request, even when it is pending and unmasked.
- R9: The combined output is high exactly when at least one pin request is high.
- R10: Bit 23 of the mode register (word 5) selects the pin mode, and it resets to 0. At 0, pins 0 to 3 show their synchronised values as a 4-bit code, with pin n on bit n, and they raise no request and hold no pending bit. At 1 they are individual pins and the code output is 0.
- R11: Sense codes 5 to 15 detect nothing.
- R12: Words 3 and 4 read as 0. Writes to words 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | NPINS | Asynchronous external interrupt pins, bit n = pin n |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_pin | output | NPINS | Per-pin interrupt requests |
| irq_any | output | 1 | OR of all pin requests |
| lvl_code | output | 4 | Encoded level from pins 0 to 3 in encoded mode |

## Verification
The hardest case to reach from the ports is an edge-type pending bit and a level-type pending bit that are both set at the same moment, followed by one source write that must clear the edge bit and leave the level bit alone. The stimulus walks a pin pattern table in which each step changes one pin, and a clearing write follows every step. This means level pins stay set across several steps while edge pins come back to zero. The directed tests then raise two edge pins together with a held level pin, and write a selective clear on top of them.

// File: rtl/extirq_pinctl.sv
module extirq_pinctl #(
  parameter int NPINS    = 8,
  parameter int SENSE_W  = 4,
  parameter int SRC_W    = 8,
  parameter int MODE_BIT = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [NPINS-1:0] irq_pin,
  output logic             irq_any,
  output logic [3:0]       lvl_code
);
  localparam int PRIO_W = 4;
  localparam int SENSE_BITS = NPINS * SENSE_W;
  localparam logic [32:0] SM_RAW = ((33'd1 << SENSE_BITS) - 33'd1) << (32 - SENSE_BITS);
  localparam logic [31:0] SENSE_MASK = SM_RAW[31:0];
  localparam logic [2:0] A_SENSE = 3'd0, A_PRIO = 3'd1, A_SRC = 3'd2,
                         A_MSET = 3'd3, A_MCLR = 3'd4, A_MODE = 3'd5;

  logic [NPINS-1:0] sy1, sy2, sy_prev, pend, pend_d, mask, mset, mclr;
  logic [31:0]      sense_q, prio_q;
  logic             mode_q;
  logic [SRC_W-1:0] src_view;
  logic             wr_sense, wr_prio, wr_src, wr_mset, wr_mclr, wr_mode;

  assign wr_sense = bus_wr && bus_addr == A_SENSE;
  assign wr_prio  = bus_wr && bus_addr == A_PRIO;
  assign wr_src   = bus_wr && bus_addr == A_SRC;
  assign wr_mset  = bus_wr && bus_addr == A_MSET;
  assign wr_mclr  = bus_wr && bus_addr == A_MCLR;
  assign wr_mode  = bus_wr && bus_addr == A_MODE;

  always_comb begin
    src_view = '0;
    for (int i = 0; i < NPINS; i++) begin
      src_view[SRC_W-1-i] = pend[i];
      mset[i] = wr_mset && bus_wdata[SRC_W-1-i];
      mclr[i] = wr_mclr && bus_wdata[SRC_W-1-i];
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    localparam int SOFF = 32 - (g + 1) * SENSE_W;
    localparam int POFF = 32 - (g + 1) * PRIO_W;
    localparam int SBIT = SRC_W - 1 - g;
    localparam bit ENC_PIN = (g < 4);
    logic [3:0] code;
    logic rise, fall, ev, lvl_act, is_lvl, gated, clr;

    assign code = 4'(sense_q[SOFF +: SENSE_W]);
    assign rise = sy2[g] && !sy_prev[g];
    assign fall = !sy2[g] && sy_prev[g];

    always_comb begin
      ev = 1'b0;
      lvl_act = 1'b0;
      is_lvl = 1'b0;
      case (code)
        4'd0: ev = fall;
        4'd1: ev = rise;
        4'd2: begin is_lvl = 1'b1; lvl_act = !sy2[g]; end
        4'd3: begin is_lvl = 1'b1; lvl_act = sy2[g]; end
        4'd4: ev = rise || fall;
        default: ev = 1'b0;
      endcase
    end

    assign gated = ENC_PIN && !mode_q;
    assign clr = wr_src && !bus_wdata[SBIT];
    assign pend_d[g] = gated ? 1'b0 : is_lvl ? lvl_act : ((pend[g] && !clr) || ev);
    assign irq_pin[g] = pend[g] && !mask[g] && !gated && (prio_q[POFF +: PRIO_W] != '0);

    a_r7_mask_write: assert property (@(posedge clk) disable iff (rst)
      (wr_mset && bus_wdata[SBIT]) |=> !irq_pin[g]);

    a_r5_level_clear_ignored: assert property (@(posedge clk) disable iff (rst)
      (wr_src && is_lvl && lvl_act && !gated) |=> pend[g]);

    a_r3_edge_origin: assert property (@(posedge clk) disable iff (rst)
      ($rose(pend[g]) && $past(!is_lvl)) |-> $past(sy2[g] != sy_prev[g]));

    if (ENC_PIN) begin : g_enc
      a_r10_encoded_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr_mode && !bus_wdata[MODE_BIT]) |=> !irq_pin[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sy1 <= '0;
      sy2 <= '0;
      sy_prev <= '0;
      pend <= '0;
      mask <= '1;
      sense_q <= '0;
      prio_q <= '0;
      mode_q <= 1'b0;
    end else begin
      sy1 <= pin_in;
      sy2 <= sy1;
      sy_prev <= sy2;
      pend <= pend_d;
      mask <= (mask | mset) & ~mclr;
      if (wr_sense) sense_q <= bus_wdata & SENSE_MASK;
      if (wr_prio)  prio_q <= bus_wdata;
      if (wr_mode)  mode_q <= bus_wdata[MODE_BIT];
    end
  end

  assign irq_any  = |irq_pin;
  assign lvl_code = mode_q ? 4'd0 : sy2[3:0];

  always_comb begin
    case (bus_addr)
      A_SENSE: bus_rdata = sense_q;
      A_PRIO:  bus_rdata = prio_q;
      A_SRC:   bus_rdata = 32'(src_view);
      A_MODE:  bus_rdata = 32'(mode_q) << MODE_BIT;
      default: bus_rdata = '0;
    endcase
  end

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irq_any);
endmodule

// File: tb/extirq_pinctl_test.sv
module extirq_pinctl_test;
  localparam int CLK_P = 10;
  localparam logic [23:0] VEC [9] = '{
    24'h07_01_01, 24'h05_02_02, 24'h01_04_04, 24'h0D_08_08, 24'h1D_18_18,
    24'h0D_18_18, 24'h2D_08_08, 24'h6D_48_48, 24'hE5_80_00};

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0;
  logic [7:0] pin_in = 8'h06;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0] irq_pin;
  logic irq_any;
  logic [3:0] lvl_code;
  int total = 0, bad = 0;
  bit done = 0;

  extirq_pinctl uut (.clk(clk), .rst(rst), .pin_in(pin_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pin(irq_pin), .irq_any(irq_any), .lvl_code(lvl_code));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [7:0] to_pins(input logic [7:0] src);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = src[7-i];
    return r;
  endfunction

  initial begin
    logic [31:0] v;
    wcyc(3);
    rst = 1'b0;
    wcyc(3);
    // R1 reset state
    rd(3'd0, v); chk("R1 sense", v, 0);
    rd(3'd1, v); chk("R1 prio", v, 0);
    rd(3'd2, v); chk("R1 source", v, 0);
    rd(3'd5, v); chk("R1 mode", v, 0);
    chk("R1 irq_pin", 32'(irq_pin), 0);
    chk("R10 reset encoded code", 32'(lvl_code), 32'h6);

    wr(3'd5, 32'h0080_0000);
    wr(3'd0, 32'h1023_4513);
    wr(3'd1, 32'hFFFF_FFF0);
    wr(3'd2, 32'h0);
    rd(3'd0, v); chk("R2 sense readback", v, 32'h1023_4513);
    rd(3'd1, v); chk("R2 prio readback", v, 32'hFFFF_FFF0);
    rd(3'd5, v); chk("R10 mode readback", v, 32'h0080_0000);
    chk("R10 code zero in individual mode", 32'(lvl_code), 0);

    // R1 masked from reset: pin0 rises, pending but silent
    pin_in = 8'h07; wcyc(4);
    rd(3'd2, v); chk("R3 pin0 pending bit7", v, 32'h80);
    chk("R1 still masked", 32'(irq_pin), 0);
    pin_in = 8'h06; wcyc(4);
    wr(3'd2, 32'h0);
    wr(3'd4, 32'hFF);
    wcyc(1);
    rd(3'd2, v); chk("R6 clear all", v, 0);

    // table walk: R3 R4 R5 R8 R9 R11
    for (int k = 0; k < 9; k++) begin
      pin_in = VEC[k][23:16];
      wcyc(4);
      rd(3'd2, v);
      chk($sformatf("R3 R4 R5 R11 step %0d pending", k), 32'(to_pins(v[7:0])), 32'(VEC[k][15:8]));
      chk($sformatf("R8 step %0d irq_pin", k), 32'(irq_pin), 32'(VEC[k][7:0]));
      chk($sformatf("R9 step %0d irq_any", k), 32'(irq_any), 32'(|VEC[k][7:0]));
      wr(3'd2, 32'h0);
      wcyc(1);
    end
    rd(3'd2, v); chk("R5 level survives clear", v, 32'h01);

    // R6 selective clear
    pin_in = 8'hA4; wcyc(4);
    pin_in = 8'hE5; wcyc(4);
    rd(3'd2, v); chk("R6 two edges plus level", v, 32'h83);
    wr(3'd2, 32'h80);
    wcyc(1);
    rd(3'd2, v); chk("R6 keep ones clear zeros", v, 32'h81);

    // R7 mask strobes
    chk("R7 baseline irq", 32'(irq_pin), 32'h01);
    wr(3'd3, 32'h80); wcyc(1);
    chk("R7 masked", 32'(irq_pin), 0);
    rd(3'd2, v); chk("R7 pending kept while masked", v, 32'h81);
    wr(3'd4, 32'h00); wcyc(1);
    chk("R7 zero clear-strobe no effect", 32'(irq_pin), 0);
    wr(3'd4, 32'h80); wcyc(1);
    chk("R7 unmasked", 32'(irq_pin), 32'h01);
    wr(3'd3, 32'h7F); wcyc(1);
    chk("R7 zero set bit no effect", 32'(irq_pin), 32'h01);
    wr(3'd4, 32'hFF);

    // R8 priority gate
    wr(3'd1, 32'h0FFF_FFF0); wcyc(1);
    chk("R8 prio zero gates pin0", 32'(irq_pin), 0);
    chk("R9 any low", 32'(irq_any), 0);
    wr(3'd1, 32'hFFFF_FFFF); wcyc(1);
    chk("R8 all enabled", 32'(irq_pin), 32'h81);
    chk("R9 any high", 32'(irq_any), 1);

    // R12 write-only and unused words
    wr(3'd6, 32'h0); wr(3'd7, 32'h0);
    rd(3'd0, v); chk("R12 sense unchanged", v, 32'h1023_4513);
    rd(3'd1, v); chk("R12 prio unchanged", v, 32'hFFFF_FFFF);
    rd(3'd3, v); chk("R12 mask-set reads 0", v, 0);
    rd(3'd4, v); chk("R12 mask-clear reads 0", v, 0);

    // R10 encoded mode
    wr(3'd5, 32'h0); wcyc(1);
    chk("R10 low pins silent", 32'(irq_pin), 32'h80);
    rd(3'd2, v); chk("R10 low pins not pending", v, 32'h01);
    chk("R10 code", 32'(lvl_code), 32'h5);
    pin_in = 8'hEA; wcyc(4);
    chk("R10 code follows pins", 32'(lvl_code), 32'hA);
    chk("R10 still silent", 32'(irq_pin), 32'h80);
    wr(3'd5, 32'h0080_0000); wcyc(1);
    chk("R10 code cleared", 32'(lvl_code), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule